// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing

This block produces the serial clock and the four active-low select lines of a serial flash controller from a faster reference clock. A small register interface with two words (control and delay) sets the clock divisor, the clock polarity and phase, the device select and its output format, and four delay values counted in reference cycles. A transfer engine asks for a transfer with a start pulse and ends it with a stop pulse. The block then runs the select-to-clock lead, the free-running serial clock, the trailing hold, the minimum deselect time and, when the next transfer goes to a different device, an extra gap.

The hardware lengthens two of the programmed delays by fixed amounts. The trailing hold gets one serial clock period plus three reference cycles. The deselect time gets one serial clock period plus one reference cycle. An idle flag, which is also bit 31 of the control word, tells software that no select is active and no timer is counting.

Top module: `flash_sclk_timing`

## Requirements
- R1: After reset all select lines are high, sclk is 0, idle is 1, the control word reads 0x8000_0000 and the delay word reads 0.
- R2: While clocking, each sclk level lasts div+1 reference cycles, so the serial clock is the reference divided by 2*(div+1).
- R3: sclk sits at the polarity level whenever no select is asserted, and it toggles only while a select is low.
- R4: With decode off, select value n (low two bits) drives cs_n = ~(1<<n), so 0 gives 1110 and 3 gives 0111. With decode on, the raw 4-bit field is driven while the select is active.
- R5: The number of reference cycles from the select falling to the first sclk edge is lead+2 with phase 1, and lead+div+2 with phase 0.
- R6: The number of reference cycles from the last sclk edge to the select rising is trail+2*div+5.
- R7: After the select rises, it stays high with idle 0 for hold+2*div+3 reference cycles, and then idle returns to 1.
- R8: If the previous transfer used a different select code and gap is nonzero, the select falls gap cycles after the start is taken (idle 0, select high). Otherwise it falls in the next cycle.
- R9: Control and delay writes take effect only while enable is 0 and the block is idle. Otherwise a control write changes only the enable bit, and a delay write is dropped.
- R10: A start is ignored unless enable is 1 and the block is idle. A stop ends the transfer on the next return of sclk to its rest level, so every transfer has a whole number of periods and at least one.
- R11: idle (the port and control bit 31) is 1 exactly when no select is asserted and no delay is counting.
- R12: Control word fields: bit 0 enable, bit 1 polarity, bit 2 phase, bit 9 decode, bits 13:10 select, bits 22:19 divisor; other bits read 0. Delay word fields: bits 7:0 lead, 15:8 trail, 23:16 gap, 31:24 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 delay |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| xfer_start | input | 1 | Start request from the transfer engine |
| xfer_stop | input | 1 | Stop request from the transfer engine |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Select lines, active low or raw code |
| idle | output | 1 | No select asserted and no delay counting |

## Verification
The hardest case to reach from the ports is the inter-device gap. It shows up only when a transfer follows a completed one that used a different select code, so the block must first run a whole transfer, be disabled, be reprogrammed and then be restarted. The bench keeps its own record of the last select code driven and runs random chains of transfers in which select, decode mode and gap all change, plus directed pairs that force both the gap case and the same-device case. The stop pulse is always issued just after an edge away from the rest level, so the bench can tell in advance which edge is the last one.

// File: rtl/flash_sclk_timing.sv
`timescale 1ns/1ps
module flash_sclk_timing #(
  parameter int DLY_W = 8,
  parameter int DIV_W = 4,
  parameter int CS_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        xfer_start,
  input  logic        xfer_stop,
  output logic        sclk,
  output logic [3:0]  cs_n,
  output logic        idle
);
  localparam int CNT_W = DLY_W + DIV_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_LEAD, S_CLK, S_TRAIL, S_HOLD} st_t;

  st_t              st;
  logic             en, cpol, cpha, dec;
  logic [CS_W-1:0]  csel;
  logic [DIV_W-1:0] div;
  logic [DLY_W-1:0] d_lead, d_trail, d_gap, d_hold;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] hc;
  logic             ph, stop_pend;
  logic [CS_W-1:0]  last_code;
  logic             have_last;
  logic [CS_W-1:0]  sel_code;
  logic [CNT_W-1:0] period;
  logic             cfg_ok, cs_act, stop_now;
  logic [31:0]      ctrl_word, dly_word;
  logic [2*DLY_W+DIV_W+CS_W+2:0] cfg_word;

  assign cfg_ok   = !en && (st == S_IDLE);
  assign sel_code = dec ? csel : ~(CS_W'(1) << csel[1:0]);
  assign period   = CNT_W'({div, 1'b0}) + CNT_W'(2);
  assign cs_act   = (st == S_LEAD) || (st == S_CLK) || (st == S_TRAIL);
  assign cs_n     = cs_act ? sel_code : {CS_W{1'b1}};
  assign sclk     = ph ^ cpol;
  assign idle     = (st == S_IDLE);
  assign stop_now = stop_pend || xfer_stop;

  assign ctrl_word = {idle, 8'd0, div, 5'd0, csel, dec, 6'd0, cpha, cpol, en};
  assign dly_word  = {d_hold, d_gap, d_trail, d_lead};
  assign cfg_rdata = cfg_sel ? dly_word : ctrl_word;
  assign cfg_word  = {cpol, cpha, dec, csel, div, d_lead, d_trail};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; dec <= 1'b0;
      csel <= '0; div <= '0;
      d_lead <= '0; d_trail <= '0; d_gap <= '0; d_hold <= '0;
    end else if (cfg_wr) begin
      if (!cfg_sel) begin
        en <= cfg_wdata[0];
        if (cfg_ok) begin
          cpol <= cfg_wdata[1];
          cpha <= cfg_wdata[2];
          dec  <= cfg_wdata[9];
          csel <= cfg_wdata[13:10];
          div  <= cfg_wdata[22:19];
        end
      end else if (cfg_ok) begin
        d_lead  <= cfg_wdata[7:0];
        d_trail <= cfg_wdata[15:8];
        d_gap   <= cfg_wdata[23:16];
        d_hold  <= cfg_wdata[31:24];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; hc <= '0; ph <= 1'b0;
      stop_pend <= 1'b0; last_code <= '1; have_last <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          stop_pend <= 1'b0;
          if (xfer_start && en) begin
            if (have_last && (last_code != sel_code) && (d_gap != '0)) begin
              st  <= S_GAP;
              cnt <= CNT_W'(d_gap) - CNT_W'(1);
            end else begin
              st  <= S_LEAD;
              cnt <= CNT_W'(d_lead);
            end
          end
        end
        S_GAP: begin
          if (cnt == '0) begin
            st  <= S_LEAD;
            cnt <= CNT_W'(d_lead);
          end else cnt <= cnt - CNT_W'(1);
        end
        S_LEAD: begin
          last_code <= sel_code;
          have_last <= 1'b1;
          if (xfer_stop) stop_pend <= 1'b1;
          if (cnt == '0) begin
            st <= S_CLK;
            ph <= 1'b0;
            hc <= cpha ? '0 : div;
          end else cnt <= cnt - CNT_W'(1);
        end
        S_CLK: begin
          if (xfer_stop) stop_pend <= 1'b1;
          if (hc == '0) begin
            hc <= div;
            if (ph && stop_now) begin
              ph  <= 1'b0;
              st  <= S_TRAIL;
              cnt <= CNT_W'(d_trail) + period + CNT_W'(2);
            end else ph <= ~ph;
          end else hc <= hc - DIV_W'(1);
        end
        S_TRAIL: begin
          if (cnt == '0) begin
            st  <= S_HOLD;
            cnt <= CNT_W'(d_hold) + period;
          end else cnt <= cnt - CNT_W'(1);
        end
        S_HOLD: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - CNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_sclk_timing_chk.sv
`timescale 1ns/1ps
module flash_sclk_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic [3:0] cs_n,
  input logic       idle,
  input logic       en,
  input logic       cpol,
  input logic       dec,
  input logic [30:0] cfg_word
);
  a_r3_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 4'hF) |-> (sclk == cpol));

  a_r3_toggle_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk) && $stable(cpol)) |-> (cs_n != 4'hF));

  a_r4_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    !dec |-> ($countones(~cs_n) <= 1));

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en || !idle) |=> $stable(cfg_word));

  a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !en) |=> idle);

  a_r11_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (cs_n == 4'hF));
endmodule

bind flash_sclk_timing flash_sclk_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .idle(idle),
  .en(en), .cpol(cpol), .dec(dec), .cfg_word(cfg_word)
);

// File: tb/flash_sclk_timing_bench.sv
`timescale 1ns/1ps
module flash_sclk_timing_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic xfer_start = 1'b0, xfer_stop = 1'b0;
  logic sclk, idle;
  logic [3:0] cs_n;

  int checks = 0, errors = 0;
  logic m_cpol, m_cpha, m_dec;
  logic [3:0] m_cs, m_div;
  logic [7:0] m_lead, m_trail, m_gap, m_hold;
  logic [3:0] m_last;
  logic m_have = 1'b0;

  always #4 clk = ~clk;

  flash_sclk_timing u_flash_sclk_timing (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_start(xfer_start),
    .xfer_stop(xfer_stop), .sclk(sclk), .cs_n(cs_n), .idle(idle)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input logic d, input logic [3:0] c);
    return d ? c : ~(4'b0001 << c[1:0]);
  endfunction

  function automatic logic [31:0] ctrl_val(input logic e, input logic p, input logic h,
                                           input logic d, input logic [3:0] c, input logic [3:0] v);
    return {9'd0, v, 5'd0, c, d, 6'd0, h, p, e};
  endfunction

  task automatic wr(input logic s, input logic [31:0] d);
    cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [31:0] d);
    cfg_sel = s; #1; d = cfg_rdata;
  endtask

  task automatic setup(input logic p, input logic h, input logic d, input logic [3:0] c,
                       input logic [3:0] v, input logic [31:0] dly);
    logic [31:0] r;
    wr(1'b0, 32'd0);
    wr(1'b0, ctrl_val(1'b0, p, h, d, c, v));
    wr(1'b1, dly);
    wr(1'b0, ctrl_val(1'b1, p, h, d, c, v));
    m_cpol = p; m_cpha = h; m_dec = d; m_cs = c; m_div = v;
    {m_hold, m_gap, m_trail, m_lead} = dly;
    rd(1'b0, r);
    chk(r == (ctrl_val(1'b1, p, h, d, c, v) | 32'h8000_0000), "R12 ctrl readback", r,
        ctrl_val(1'b1, p, h, d, c, v) | 32'h8000_0000);
    rd(1'b1, r);
    chk(r == dly, "R12 delay readback", r, dly);
  endtask

  task automatic xfer(input int nper);
    int n, edges, run;
    bit sent, hp_ok, rest_ok;
    logic last;
    logic [3:0] code;
    int exp_gap;
    code = exp_code(m_dec, m_cs);
    exp_gap = (m_have && m_last != code && m_gap != 0) ? int'(m_gap) : 0;
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    n = 0;
    while (cs_n == 4'hF && n < 2000) begin
      if (idle) n = 5000;
      n++; @(negedge clk);
    end
    chk(n == exp_gap, "R8 gap before select", n, exp_gap);
    chk(cs_n == code, "R4 select code", cs_n, code);
    m_last = code; m_have = 1'b1;
    n = 0;
    while (sclk == m_cpol && n < 2000) begin n++; @(negedge clk); end
    chk(n == int'(m_lead) + 2 + (m_cpha ? 0 : int'(m_div)), "R5 select to first edge", n,
        int'(m_lead) + 2 + (m_cpha ? 0 : int'(m_div)));
    edges = 1; last = sclk; run = 0; sent = 1'b0; hp_ok = 1'b1;
    for (int g = 0; g < 4000; g++) begin
      run++;
      if (edges == 2*nper - 1 && !sent) begin xfer_stop = 1'b1; sent = 1'b1; end
      @(negedge clk);
      xfer_stop = 1'b0;
      if (sclk != last) begin
        edges++;
        if (run != int'(m_div) + 1) hp_ok = 1'b0;
        run = 0; last = sclk;
        if (sent && sclk == m_cpol) break;
      end
    end
    chk(hp_ok, "R2 half period", run, int'(m_div) + 1);
    chk(edges == 2*nper, "R10 whole periods on stop", edges, 2*nper);
    n = 0; rest_ok = 1'b1;
    while (cs_n != 4'hF && n < 2000) begin
      if (sclk != m_cpol) rest_ok = 1'b0;
      n++; @(negedge clk);
    end
    chk(n == int'(m_trail) + 2*int'(m_div) + 5, "R6 last edge to deselect", n,
        int'(m_trail) + 2*int'(m_div) + 5);
    chk(rest_ok && sclk == m_cpol, "R3 rest level after last edge", sclk, m_cpol);
    n = 0;
    while (!idle && n < 2000) begin
      if (cs_n != 4'hF) rest_ok = 1'b0;
      n++; @(negedge clk);
    end
    chk(n == int'(m_hold) + 2*int'(m_div) + 3, "R7 deselect hold", n,
        int'(m_hold) + 2*int'(m_div) + 3);
    chk(rest_ok && cs_n == 4'hF && idle, "R11 idle with select high", {idle, cs_n}, 5'h1F);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] old;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF && sclk == 1'b0 && idle, "R1 reset outputs", {cs_n, sclk, idle}, 6'h3D);
    rd(1'b0, r); chk(r == 32'h8000_0000, "R1 reset ctrl", r, 32'h8000_0000);
    rd(1'b1, r); chk(r == 32'h0, "R1 reset delay", r, 0);

    setup(1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 32'h0);
    xfer(1);

    // R10: start while disabled
    wr(1'b0, ctrl_val(1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0));
    xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 6; i++) begin
        if (cs_n != 4'hF || !idle) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R10 start ignored when disabled", cs_n, 4'hF);
    end

    // R9: writes while enabled
    setup(1'b1, 1'b1, 1'b0, 4'd2, 4'd3, 32'h0403_0201);
    old = ctrl_val(1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 4'd3) | 32'h8000_0000;
    wr(1'b0, ctrl_val(1'b1, 1'b0, 1'b0, 1'b1, 4'd7, 4'd9));
    rd(1'b0, r); chk(r == old, "R9 ctrl write blocked while enabled", r, old);
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, r); chk(r == 32'h0403_0201, "R9 delay write blocked", r, 32'h0403_0201);
    wr(1'b0, ctrl_val(1'b0, 1'b0, 1'b0, 1'b1, 4'd7, 4'd9));
    rd(1'b0, r); chk(r == (old & ~32'h1), "R9 only enable cleared", r, old & ~32'h1);
    wr(1'b0, ctrl_val(1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 4'd3));
    xfer(2);

    // R10: start while busy is ignored, enable cleared mid transfer keeps running
    xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
    @(negedge clk);
    chk(!idle, "R11 busy after start", idle, 0);
    wr(1'b0, ctrl_val(1'b0, 1'b0, 1'b0, 1'b1, 4'd9, 4'd0));
    rd(1'b0, r);
    chk(r[22:1] == old[22:1], "R9 fields held while busy", r, old);
    for (int i = 0; i < 400 && !idle; i++) begin
      xfer_stop = (sclk != m_cpol);
      @(negedge clk);
    end
    xfer_stop = 1'b0;
    chk(idle && cs_n == 4'hF, "R10 transfer ends after disable", {idle, cs_n}, 5'h1F);

    // R8 directed: different device then same device
    setup(1'b0, 1'b0, 1'b0, 4'd1, 4'd1, 32'h0207_0301);
    xfer(1);
    setup(1'b0, 1'b1, 1'b0, 4'd1, 4'd0, 32'h0005_0000);
    xfer(1);
    setup(1'b0, 1'b0, 1'b1, 4'hA, 4'd2, 32'h0105_0203);
    xfer(1);

    // large delays, largest divisor
    setup(1'b1, 1'b0, 1'b0, 4'd3, 4'd15, 32'hFFFF_FFFF);
    xfer(1);

    for (int t = 0; t < 24; t++) begin
      logic [31:0] dly;
      dly = {4'd0, 4'($urandom_range(0, 12)), 3'd0, 5'($urandom_range(0, 9)),
             4'd0, 4'($urandom_range(0, 12)), 4'd0, 4'($urandom_range(0, 12))};
      setup(1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
            4'($urandom), 4'($urandom_range(0, 6)), dly);
      xfer(int'($urandom_range(1, 3)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule